// File: doc/BRIEF.md
# Channel-Major Logic Sample Packer

This block takes up to sixteen digital probe levels and turns them into a byte stream. Each enabled probe's samples are grouped into 16-bit words rather than sent one tick at a time. A sample is taken on every clock cycle where the sample strobe is high. For each enabled probe, sixteen successive samples are gathered into one word. When the sixteenth sample of a group arrives, the words of all enabled probes move into an output buffer as one group. The group then leaves as two bytes per probe, in ascending probe order. A valid/ready handshake governs each byte.

Capture and draining overlap because there are two stores. The capture store keeps filling with the next group while the output buffer drains the previous one. A narrow mode input picks 3, 6, 9 or 16 enabled probes. Fewer probes give shorter groups, so a fixed output byte rate can carry a higher sample rate. Suppose a group completes while the output buffer still holds bytes that have not been sent. The new group is then discarded and a sticky overflow flag is raised.

Top module: `sample_packer`

## Requirements
- R1: `mode_i` selects the enabled probe count: 0 gives 3, 1 gives 6, 2 gives 9 and 3 gives 16. The enabled probes are inputs 0 to N-1. Each accepted group emits exactly 2N bytes, after which `byte_valid_o` is low unless another group has been accepted.
- R2: Bit i of a probe's word is that probe's level at the i-th strobed sample of the group. Bit 0 is the earliest sample, 1 means high and 0 means low. Cycles with `smp_stb_i` low take no sample.
- R3: Within a group, the bytes run probe 0 first and ascend by probe number. Each probe sends its low byte (bits 7:0) before its high byte (bits 15:8).
- R4: While `byte_valid_o` is high and `byte_ready_i` is low, the next cycle keeps `byte_valid_o` high and `byte_o` unchanged. A byte is consumed only on a cycle with both high.
- R5: When the output buffer is free at the clock edge that takes the 16th sample, `byte_valid_o` is high from the next cycle on, presenting probe 0's low byte.
- R6: Sampling never stalls while bytes drain. A completing group is accepted when the output buffer is empty, or when its last byte is consumed at that same edge.
- R7: When a group completes while the buffer is occupied and its last byte is not leaving, the group is dropped. `ovf_o` then goes high one cycle later and stays high until reset.
- R8: The mode is latched on the first sample of each group. Changes to `mode_i` later in the group do not alter that group's probe count.
- R9: After reset, `byte_valid_o` and `ovf_o` are low and the next strobe begins a new group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| probe_i | input | NPROBE (16) | Probe levels |
| smp_stb_i | input | 1 | Take one sample this cycle |
| mode_i | input | 2 | Probe count select (R1 encoding) |
| byte_o | output | BYTE_W (8) | Output byte |
| byte_valid_o | output | 1 | Output byte valid |
| byte_ready_i | input | 1 | Consumer accepts byte |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
A slipped sample counter or a mode latched at the wrong time changes where group boundaries fall. The stream then shows wrong bits or a wrong byte count within one group, about sixteen strobes. A wrong buffer index or probe count shows in the very next byte, or as `byte_valid_o` staying high or dropping one byte too early. A wrong free test between the two stores either raises `ovf_o` on the exact edge where the last byte leaves, or loses a group silently. The back-to-back boundary case exposes this at once.

// File: rtl/spk_pkg.sv
package spk_pkg;
   typedef enum logic [1:0] {
      SPK_P3  = 2'd0,
      SPK_P6  = 2'd1,
      SPK_P9  = 2'd2,
      SPK_PALL = 2'd3
   } spk_mode_e;
endpackage

// File: rtl/spk_capture.sv
module spk_capture
   import spk_pkg::*;
#(
   parameter int NPROBE = 16,
   parameter int WORD_W = 16,
   localparam int CW    = $clog2(WORD_W)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     stb_i,
   input  logic [NPROBE-1:0]        samp_i,
   input  spk_mode_e                mode_i,
   output logic                     done_o,
   output logic [NPROBE*WORD_W-1:0] words_o,
   output spk_mode_e                grp_mode_o,
   output logic [CW-1:0]            cnt_o
);
   logic [CW-1:0] cnt_q;
   spk_mode_e     mode_q;

   assign done_o     = stb_i && (cnt_q == CW'(WORD_W - 1));
   assign grp_mode_o = mode_q;
   assign cnt_o      = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         mode_q <= SPK_P3;
      end else if (stb_i) begin
         cnt_q <= done_o ? '0 : cnt_q + 1'b1;
         if (cnt_q == '0) mode_q <= mode_i;
      end
   end

   for (genvar p = 0; p < NPROBE; p++) begin : g_lane
      logic [WORD_W-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     sh_q <= '0;
         else if (stb_i) sh_q <= {samp_i[p], sh_q[WORD_W-1:1]};
      end
      assign words_o[p*WORD_W +: WORD_W] = {samp_i[p], sh_q[WORD_W-1:1]};
   end
endmodule

// File: rtl/spk_drain.sv
module spk_drain #(
   parameter int NPROBE = 16,
   parameter int WORD_W = 16,
   parameter int BYTE_W = 8,
   localparam int BPW   = WORD_W / BYTE_W,
   localparam int NB    = NPROBE * BPW,
   localparam int IW    = $clog2(NB),
   localparam int NW    = $clog2(NPROBE + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load_i,
   input  logic [NPROBE*WORD_W-1:0] load_words_i,
   input  logic [NW-1:0]            load_n_i,
   input  logic                     ready_i,
   output logic                     valid_o,
   output logic [BYTE_W-1:0]        data_o,
   output logic                     free_o
);
   logic [NPROBE*WORD_W-1:0] buf_q;
   logic                     busy_q;
   logic [IW-1:0]            idx_q;
   logic [NW-1:0]            n_q;
   logic                     hs, last;

   assign hs      = busy_q && ready_i;
   assign last    = int'(idx_q) == int'(n_q) * BPW - 1;
   assign free_o  = !busy_q || (hs && last);
   assign valid_o = busy_q;
   assign data_o  = buf_q[idx_q*BYTE_W +: BYTE_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q  <= '0;
         busy_q <= 1'b0;
         idx_q  <= '0;
         n_q    <= '0;
      end else if (load_i) begin
         buf_q  <= load_words_i;
         n_q    <= load_n_i;
         idx_q  <= '0;
         busy_q <= 1'b1;
      end else if (hs) begin
         if (last) busy_q <= 1'b0;
         else      idx_q  <= idx_q + 1'b1;
      end
   end
endmodule

// File: rtl/sample_packer.sv
module sample_packer
   import spk_pkg::*;
#(
   parameter int NPROBE = 16,
   parameter int WORD_W = 16,
   parameter int BYTE_W = 8,
   localparam int NW    = $clog2(NPROBE + 1),
   localparam int CW    = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPROBE-1:0] probe_i,
   input  logic              smp_stb_i,
   input  logic [1:0]        mode_i,
   output logic [BYTE_W-1:0] byte_o,
   output logic              byte_valid_o,
   input  logic              byte_ready_i,
   output logic              ovf_o
);
   initial begin
      assert (NPROBE >= 10 && WORD_W >= 2 && WORD_W % BYTE_W == 0)
         else $error("sample_packer: unsupported parameter set");
   end

   logic                     grp_done, buf_free, ovf_q;
   logic [NPROBE*WORD_W-1:0] grp_words;
   spk_mode_e                grp_mode;
   logic [CW-1:0]            samp_cnt;
   logic [NW-1:0]            grp_n;

   spk_capture #(.NPROBE(NPROBE), .WORD_W(WORD_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .stb_i(smp_stb_i), .samp_i(probe_i),
      .mode_i(spk_mode_e'(mode_i)), .done_o(grp_done), .words_o(grp_words),
      .grp_mode_o(grp_mode), .cnt_o(samp_cnt)
   );

   always_comb begin
      unique case (grp_mode)
         SPK_P3:  grp_n = NW'(3);
         SPK_P6:  grp_n = NW'(6);
         SPK_P9:  grp_n = NW'(9);
         default: grp_n = NW'(NPROBE);
      endcase
   end

   spk_drain #(.NPROBE(NPROBE), .WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_drn (
      .clk(clk), .rst_n(rst_n), .load_i(grp_done && buf_free),
      .load_words_i(grp_words), .load_n_i(grp_n), .ready_i(byte_ready_i),
      .valid_o(byte_valid_o), .data_o(byte_o), .free_o(buf_free)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    ovf_q <= 1'b0;
      else if (grp_done && !buf_free) ovf_q <= 1'b1;
   end
   assign ovf_o = ovf_q;
endmodule

// File: rtl/spk_chk.sv
module spk_chk #(
   parameter int BYTE_W = 8,
   parameter int CW     = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              grp_done,
   input logic              buf_free,
   input logic              byte_valid_o,
   input logic              byte_ready_i,
   input logic [BYTE_W-1:0] byte_o,
   input logic              ovf_o,
   input logic [CW-1:0]     samp_cnt,
   input logic [1:0]        grp_mode
);
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid_o && !byte_ready_i |=> byte_valid_o && $stable(byte_o));
   p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      grp_done && buf_free |=> byte_valid_o);
   p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      grp_done && !buf_free |=> ovf_o);
   p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> ovf_o);
   p_mode_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
      samp_cnt != '0 |=> $stable(grp_mode));
endmodule

bind sample_packer spk_chk #(.BYTE_W(BYTE_W), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .grp_done(grp_done), .buf_free(buf_free),
   .byte_valid_o(byte_valid_o), .byte_ready_i(byte_ready_i), .byte_o(byte_o),
   .ovf_o(ovf_o), .samp_cnt(samp_cnt), .grp_mode(grp_mode)
);

// File: tb/sample_packer_bench.sv
module sample_packer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] probe = '0;
   logic        stb = 1'b0;
   logic [1:0]  mode = 2'd0;
   logic        rdy = 1'b0;
   logic [7:0]  byte_o;
   logic        byte_valid, ovf;

   int total = 0;
   int bad = 0;

   logic [7:0]  q[$];
   logic [15:0] hist[16];
   int          mcnt = 0;
   logic [1:0]  mmode = 2'd0;
   logic        m_ovf = 1'b0;
   logic        hold_prev = 1'b0;
   logic [7:0]  hold_data = '0;

   always #2 clk = ~clk;

   sample_packer u_sample_packer (
      .clk(clk), .rst_n(rst_n), .probe_i(probe), .smp_stb_i(stb),
      .mode_i(mode), .byte_o(byte_o), .byte_valid_o(byte_valid),
      .byte_ready_i(rdy), .ovf_o(ovf)
   );

   function automatic int probes_of(input logic [1:0] m);
      case (m)
         2'd0: return 3;
         2'd1: return 6;
         2'd2: return 9;
         default: return 16;
      endcase
   endfunction

   function automatic logic [15:0] word_of(input int p);
      logic [15:0] w;
      for (int i = 0; i < 16; i++) w[i] = hist[i][p];
      return w;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; stb = 1'b0; rdy = 1'b0;
      q.delete(); mcnt = 0; m_ovf = 1'b0; hold_prev = 1'b0;
      repeat (2) @(negedge clk);
      #1;
      chk(byte_valid == 1'b0, "R9 valid after reset", int'(byte_valid), 0);
      chk(ovf == 1'b0, "R9 ovf after reset", int'(ovf), 0);
      rst_n = 1'b1;
   endtask

   task automatic step(input logic s, input logic [15:0] d, input logic r, input logic [1:0] m);
      @(negedge clk);
      stb = s; probe = d; rdy = r; mode = m;
      #1;
      chk(ovf == m_ovf, "R7 ovf", int'(ovf), int'(m_ovf));
      chk(byte_valid == (q.size() != 0), "R1/R5 valid", int'(byte_valid), int'(q.size() != 0));
      if (hold_prev) chk(byte_o == hold_data, "R4 held byte", int'(byte_o), int'(hold_data));
      hold_prev = byte_valid && !r;
      hold_data = byte_o;
      if (byte_valid && r && q.size() != 0) begin
         chk(byte_o == q[0], "R2/R3 byte", int'(byte_o), int'(q[0]));
         void'(q.pop_front());
      end
      if (s) begin
         if (mcnt == 0) mmode = m;
         hist[mcnt] = d;
         if (mcnt == 15) begin
            if (q.size() == 0) begin
               for (int p = 0; p < probes_of(mmode); p++) begin
                  logic [15:0] w;
                  w = word_of(p);
                  q.push_back(w[7:0]);
                  q.push_back(w[15:8]);
               end
            end else begin
               m_ovf = 1'b1;
            end
         end
         mcnt = (mcnt + 1) % 16;
      end
   endtask

   initial begin
      #(4 * 100000);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int seed;
      seed = $urandom(32'd20240611);
      do_reset();
      // R1 R2 R3: all probes, walking one, continuous strobe and ready
      for (int i = 0; i < 16; i++) step(1'b1, 16'h1 << i, 1'b1, 2'd3);
      for (int i = 0; i < 40; i++) step(1'b0, 16'hffff, 1'b1, 2'd3);
      // R6: next group completes exactly as the last byte of the previous one leaves
      for (int i = 0; i < 16; i++) step(1'b1, 16'($urandom), 1'b1, 2'd3);
      for (int i = 0; i < 16; i++) step(1'b0, 16'h0, 1'b1, 2'd3);
      for (int i = 0; i < 16; i++) step(1'b1, 16'($urandom), 1'b1, 2'd3);
      for (int i = 0; i < 40; i++) step(1'b0, 16'h0, 1'b1, 2'd3);
      // R8 R2 R4: random strobes, random back-pressure, mode changing freely
      for (int i = 0; i < 1500; i++)
         step(($urandom % 10) < 3, 16'($urandom), ($urandom % 10) < 8, 2'($urandom % 3));
      for (int i = 0; i < 60; i++) step(1'b0, 16'h0, 1'b1, 2'd0);
      // R4: long stall holds the byte
      for (int i = 0; i < 16; i++) step(1'b1, 16'($urandom), 1'b0, 2'd1);
      for (int i = 0; i < 10; i++) step(1'b0, 16'h0, 1'b0, 2'd1);
      for (int i = 0; i < 20; i++) step(1'b0, 16'h0, 1'b1, 2'd1);
      // R7: second group while first is stalled -> dropped, flag sticky
      for (int i = 0; i < 32; i++) step(1'b1, 16'($urandom), 1'b0, 2'd3);
      for (int i = 0; i < 50; i++) step(1'b0, 16'h0, 1'b1, 2'd3);
      chk(ovf == 1'b1, "R7 sticky", int'(ovf), 1);
      // R9: reset clears, then a fresh group in 9-probe mode
      do_reset();
      for (int i = 0; i < 16; i++) step(1'b1, 16'($urandom), 1'b1, 2'd2);
      for (int i = 0; i < 30; i++) step(1'b0, 16'h0, 1'b1, 2'd2);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule